// File: doc/BRIEF.md
# Synchronous Static Word Memory with Shared Data Bus

This block is a clocked word memory with the pin behaviour of a classic static RAM. It has one address input and one bidirectional data bus that carries write data into the block and read data out of it. Three active-low strobes control it: a select, an output gate and a write strobe. A row decoder turns the address into a one-hot row select. Every bit of the chosen row shares that select and the common write strobe. Each data bit line is shared by all words in its column.

A bus master drives the bus and pulls the write strobe low with the block selected, and the word is stored on the next rising edge. To read, the master releases the bus, holds the write strobe high, and pulls the select and output gate low. The addressed word then appears on the bus one clock later. In every other case the block leaves the bus at high impedance. The master and the memory can therefore share the bus with no extra steering logic.

Top module: `sram_wordmem`

## Requirements
- R1: A rising clock edge with `cs_ni` low and `we_ni` low stores the value on `data_io` into the word at `addr_i`.
- R2: While `cs_ni` is high the block leaves `data_io` at high impedance, and no edge in that state changes any stored word.
- R3: While `oe_ni` is high the block does not drive `data_io`, even if the previous edge captured a selected read.
- R4: While `we_ni` is low the block never drives `data_io`. `oe_ni` has no effect on whether a write is stored.
- R5: The array holds 2^ADDR_W words of DATA_W bits. A write changes only the addressed word.
- R6: At most one row select is active at any time, so at most one stored word feeds the read path.
- R7: An edge with `cs_ni` low and `we_ni` high captures the word at `addr_i`. In the following cycle the block drives that word on `data_io` for as long as `cs_ni` is low, `oe_ni` is low and `we_ni` is high.
- R8: After reset the block does not drive `data_io` until it has captured a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; storage and read capture on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| data_io | inout | DATA_W | Shared data bus: write data in, read data out |
| cs_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output gate, active low |
| we_ni | input | 1 | Write strobe, active low (high selects a read) |

## Verification
The bench puts a pull-up on the bus, so a released bus reads all ones. The stored patterns avoid all ones, which makes any stray drive visible. It checks the bus stays released in four cases: right after reset, with select high, with the output gate high, and during a write with the output gate low. A block that gated its drivers wrongly would instead place a stale word on the bus there. A write attempted with select high must leave the old word in place; a block that ignored select would overwrite it. The bench also reads different addresses back to back and checks the one-cycle latency at the lowest and highest addresses. A block with a wrong latency or a faulty decoder would return the neighbouring or previous word.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/sram_ctrl_dec.sv
module sram_ctrl_dec
  import sram_pkg::*;
(
  input  logic cs_ni,
  input  logic oe_ni,
  input  logic we_ni,
  output cyc_e cyc_o,
  output logic out_gate_o
);
  always_comb begin
    if (cs_ni)       cyc_o = CYC_IDLE;
    else if (!we_ni) cyc_o = CYC_WRITE;
    else             cyc_o = CYC_READ;
  end
  // drivers may open only in a selected, output-enabled read
  assign out_gate_o = (cyc_o == CYC_READ) && !oe_ni;
endmodule

// File: rtl/sram_row_dec.sv
module sram_row_dec #(
  parameter int ADDR_W = 11,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DEPTH-1:0]  row_sel_o
);
  always_comb begin
    row_sel_o = '0;
    row_sel_o[addr_i] = 1'b1;
  end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic [DEPTH-1:0]  row_sel_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int r = 0; r < DEPTH; r++) begin
      if (wr_i && row_sel_i[r]) mem_q[r] <= wdata_i;
    end
  end

  // column bit lines: and-or of all rows, only the selected row contributes
  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < DEPTH; r++) begin
      rdata_o = rdata_o | (mem_q[r] & {DATA_W{row_sel_i[r]}});
    end
  end
endmodule

// File: rtl/sram_wordmem.sv
module sram_wordmem
  import sram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  inout  wire  [DATA_W-1:0] data_io,
  input  logic              cs_ni,
  input  logic              oe_ni,
  input  logic              we_ni
);
  cyc_e              cyc;
  logic              out_gate;
  logic [DEPTH-1:0]  row_sel;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] rd_q;
  logic              rd_vld_q;
  logic              drive_en;

  sram_ctrl_dec i_ctrl (
    .cs_ni      (cs_ni),
    .oe_ni      (oe_ni),
    .we_ni      (we_ni),
    .cyc_o      (cyc),
    .out_gate_o (out_gate)
  );

  sram_row_dec #(.ADDR_W(ADDR_W)) i_row_dec (
    .addr_i    (addr_i),
    .row_sel_o (row_sel)
  );

  sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .clk_i     (clk_i),
    .row_sel_i (row_sel),
    .wr_i      (cyc == CYC_WRITE),
    .wdata_i   (data_io),
    .rdata_o   (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= (cyc == CYC_READ);
      if (cyc == CYC_READ) rd_q <= rdata;
    end
  end

  assign drive_en = rd_vld_q && out_gate;
  assign data_io  = drive_en ? rd_q : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_wordmem_chk.sv
module sram_wordmem_chk #(
  parameter int ADDR_W = 11,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             oe_ni,
  input logic             we_ni,
  input logic [DEPTH-1:0] row_sel,
  input logic             drive_en
);
  AST_NO_DRIVE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> !drive_en); // R4
  AST_DESELECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !drive_en); // R2
  AST_OE_GATES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_en); // R3
  AST_ROW_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_sel)); // R6
  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && we_ni && !oe_ni) |=> (drive_en || cs_ni || !we_ni || oe_ni)); // R7
  AST_ROW_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(row_sel) == 1); // R5
endmodule

bind sram_wordmem sram_wordmem_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .oe_ni    (oe_ni),
  .we_ni    (we_ni),
  .row_sel  (row_sel),
  .drive_en (drive_en)
);

// File: tb/test_sram_wordmem.sv
module test_sram_wordmem;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam logic [DW-1:0] REL = '1; // released bus reads all ones

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic          tb_en = 1'b0;
  logic [DW-1:0] tb_d = '0;
  wire  [DW-1:0] bus;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  assign bus = tb_en ? tb_d : {DW{1'bz}};
  for (genvar g = 0; g < DW; g++) begin : g_pu
    pullup (bus[g]);
  end

  sram_wordmem #(.ADDR_W(AW), .DATA_W(DW)) i_sram_wordmem (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_io(bus),
    .cs_ni(cs_n), .oe_ni(oe_n), .we_ni(we_n)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic oe, input logic cs);
    @(negedge clk);
    addr = a; tb_d = d; tb_en = 1'b1; cs_n = cs; we_n = 1'b0; oe_n = oe;
    @(posedge clk);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    tb_en = 1'b0; addr = a; cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    @(posedge clk); #1;
    chk(req, bus, exp);
  endtask

  task automatic idle();
    @(negedge clk);
    tb_en = 1'b0; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk); cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; #0.5;
    chk("R8 no drive before first read", bus, REL);
    idle();
  endtask

  task automatic t_basic();
    wr('0, 8'h00, 1'b1, 1'b0);
    wr({AW{1'b1}}, 8'hA5, 1'b1, 1'b0);
    wr(11'd5, 8'h3C, 1'b1, 1'b0);
    wr(11'd6, 8'hC3, 1'b1, 1'b0);
    rd_chk('0, 8'h00, "R1 low address");
    rd_chk({AW{1'b1}}, 8'hA5, "R5 top address");
    rd_chk(11'd5, 8'h3C, "R7 back-to-back read 5");
    rd_chk(11'd6, 8'hC3, "R6 neighbour word 6");
    idle();
  endtask

  task automatic t_oe_gate();
    rd_chk(11'd5, 8'h3C, "R7 read before gate");
    @(negedge clk); oe_n = 1'b1; #0.5;
    chk("R3 oe high releases bus", bus, REL);
    @(posedge clk); #1;
    chk("R3 oe high selected read", bus, REL);
    idle();
  endtask

  task automatic t_deselect();
    rd_chk(11'd6, 8'hC3, "R7 read before deselect");
    @(negedge clk); cs_n = 1'b1; #0.5;
    chk("R2 cs high releases bus", bus, REL);
    wr(11'd5, 8'h11, 1'b0, 1'b1);
    #1; tb_en = 1'b0;
    #0.5; chk("R2 deselected write leaves bus free", bus, REL);
    rd_chk(11'd5, 8'h3C, "R2 deselected write ignored");
    idle();
  endtask

  task automatic t_write_oe_low();
    rd_chk(11'd6, 8'hC3, "R7 read before write");
    wr(11'd9, 8'h5A, 1'b0, 1'b0);
    #1; chk("R4 no contention during write", bus, 8'h5A);
    @(negedge clk); tb_en = 1'b0; #0.5;
    chk("R4 bus released while we low", bus, REL);
    we_n = 1'b1; #0.5;
    chk("R7 no drive before read capture", bus, REL);
    addr = 11'd9;
    @(posedge clk); #1;
    chk("R4 write with oe low stored", bus, 8'h5A);
    rd_chk(11'd6, 8'hC3, "R5 neighbour untouched");
    idle();
  endtask

  initial begin
    #9 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_oe_gate();
    t_deselect();
    t_write_oe_low();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule